// File: doc/BRIEF.md
# Cache Control Operation Sequencer

This block takes one decoded cache-management operation at a time (touch, touch-for-store, zero, store, flush, allocate, invalidate or instruction-invalidate), together with its effective address and two page attributes: a direct-store flag and a coherency-required flag. It settles whether the operation does nothing, drives the translation port for touches, and steps a touch through an L1 query, an L2 query and, on a double miss, a burst read on the system bus. Operations that must be visible to other agents are raised as bus broadcasts.

Each port pair is a plain hold-until-answered handshake. The block raises one request at a time and keeps it high until the matching done or grant input arrives. It finishes every operation with a one-cycle done pulse that carries a no-op flag. A separate path filters incoming snooped cache-control broadcasts. Only those marked global are passed on, one cycle later. The memory management unit, the cache arrays and the bus timing sit outside the block.

Top module: `cacheOpSeq`

## Requirements
- R1: `reqReady` is high only while idle. It drops on the edge that accepts a request and stays low until the `doneValid` pulse has ended. `doneValid` is high for exactly one cycle.
- R2: Any operation with `reqDirect` = 1 completes in the cycle after acceptance with `doneNoop` = 1. It raises no translation, cache or bus request.
- R3: A touch or touch-for-store with `cfgNoTouch` = 1 completes in the cycle after acceptance with `doneNoop` = 1, and `xlatReq` never rises.
- R4: Any other touch raises `xlatReq` in the cycle after acceptance, carrying the full byte address. `xlatReq` is held until `xlatDone`.
- R5: A translation answered with `xlatValid` = 0, `xlatLoadOk` = 0, `xlatInhibit` = 1 or `cacheLocked` = 1 gives a done pulse with `doneNoop` = 1 on the next cycle, and no L1 query is made.
- R6: After a clean translation, the touch queries L1, then on an L1 miss queries L2. A hit at either level ends the operation with `doneNoop` = 0 and no bus request. Cache and bus addresses are line-aligned, with the low `LINE_BITS` bits at zero.
- R7: On an L2 miss a touch raises `busReq` with `busKind` = 0 (read, no intent to modify). A touch-for-store uses `busKind` = 1 (read with intent to modify).
- R8: Store (op 3), flush (op 4) and invalidate (op 6) broadcast only when `reqCoherent` = 1, with `busKind` 2, 3 and 4 respectively. With `reqCoherent` = 0 they complete with `doneNoop` = 0 and no bus request.
- R9: Instruction-invalidate (op 7) always broadcasts with `busKind` = 5, whatever `reqCoherent` is.
- R10: Zero (op 2) and allocate (op 5) complete in the cycle after acceptance with `doneNoop` = 0 and no external request.
- R11: `busReq` is held until `busGrant`. The done pulse, with `doneNoop` = 0, follows in the next cycle.
- R12: `snoopAct` pulses one cycle after `snoopValid` and `snoopGlobal` are both high, and then carries that snoop's op and address. A snoop with `snoopGlobal` = 0 leaves `snoopAct` low.
- R13: A synchronous high `rst` returns the block to idle on the next edge, with every request output and `doneValid` low.
- Op codes: touch 0, touch-for-store 1, zero 2, store 3, flush 4, allocate 5, invalidate 6, instruction-invalidate 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Operation offered |
| reqReady | output | 1 | Sequencer idle and accepting |
| reqOp | input | 3 | Operation code |
| reqAddr | input | AW | Effective byte address |
| reqDirect | input | 1 | Page is a direct-store segment |
| reqCoherent | input | 1 | Page requires memory coherency |
| cfgNoTouch | input | 1 | Configuration: treat touches as no-ops |
| cacheLocked | input | 1 | Data cache locked or disabled |
| xlatReq | output | 1 | Translation and load-protection check request |
| xlatAddr | output | AW | Byte address to translate |
| xlatDone | input | 1 | Translation answer present |
| xlatValid | input | 1 | A valid translation was found |
| xlatLoadOk | input | 1 | Loads are permitted to the page |
| xlatInhibit | input | 1 | Page is caching-inhibited |
| l1Req | output | 1 | L1 data cache lookup request |
| l1Addr | output | AW | Line address for L1 |
| l1Done | input | 1 | L1 answer present |
| l1Hit | input | 1 | Line present in L1 |
| l2Req | output | 1 | L2 lookup request |
| l2Addr | output | AW | Line address for L2 |
| l2Done | input | 1 | L2 answer present |
| l2Hit | input | 1 | Line present in L2 |
| busReq | output | 1 | System bus request |
| busKind | output | 3 | 0 read, 1 read-modify, 2 store, 3 flush, 4 invalidate, 5 instruction-invalidate |
| busAddr | output | AW | Line address on the bus |
| busGrant | input | 1 | Bus accepts the request |
| doneValid | output | 1 | Operation finished, one cycle |
| doneNoop | output | 1 | Finished operation had no effect |
| snoopValid | input | 1 | Snooped cache-control broadcast present |
| snoopGlobal | input | 1 | Snoop marked global |
| snoopOp | input | 3 | Snooped operation code |
| snoopAddr | input | AW | Snooped address |
| snoopAct | output | 1 | Snoop to be acted on |
| snoopActOp | output | 3 | Op code of the accepted snoop |
| snoopActAddr | output | AW | Address of the accepted snoop |

## Verification
A global snoop can arrive in the same cycle that the sequencer sits on an ungranted touch burst read, and even in the cycle the grant comes. The bench sends the snoop in exactly that cycle and checks that `snoopAct` carries the snoop's op and address while `busReq` stays held. It also checks that the later grant still produces a clean done. A second case holds a new request through the done pulse of the previous one. It is judged by `reqReady` staying low in that cycle and the request being taken only on the next.

// File: rtl/cop_pkg.sv
package cop_pkg;

  typedef enum logic [2:0] {
    OP_TOUCH    = 3'd0,
    OP_TOUCH_ST = 3'd1,
    OP_ZERO     = 3'd2,
    OP_STORE    = 3'd3,
    OP_FLUSH    = 3'd4,
    OP_ALLOC    = 3'd5,
    OP_INVAL    = 3'd6,
    OP_IINVAL   = 3'd7
  } opCodeT;

  typedef enum logic [2:0] {
    BK_READ     = 3'd0,
    BK_READ_MOD = 3'd1,
    BK_STORE    = 3'd2,
    BK_FLUSH    = 3'd3,
    BK_INVAL    = 3'd4,
    BK_IINVAL   = 3'd5
  } busKindT;

  typedef enum logic [2:0] {
    S_IDLE,
    S_XLAT,
    S_L1,
    S_L2,
    S_BUS,
    S_DONE
  } seqStateT;

  typedef struct packed {
    logic capture;
    logic markNoop;
    logic xlatOn;
    logic l1On;
    logic l2On;
    logic busOn;
    logic doneOn;
  } seqStrobeT;

  function automatic logic isTouchOp(input logic [2:0] op);
    return (op == OP_TOUCH) || (op == OP_TOUCH_ST);
  endfunction

  function automatic logic isCoherentBcast(input logic [2:0] op);
    return (op == OP_STORE) || (op == OP_FLUSH) || (op == OP_INVAL);
  endfunction

  function automatic busKindT kindOf(input logic [2:0] op);
    case (op)
      OP_TOUCH_ST: return BK_READ_MOD;
      OP_STORE:    return BK_STORE;
      OP_FLUSH:    return BK_FLUSH;
      OP_INVAL:    return BK_INVAL;
      OP_IINVAL:   return BK_IINVAL;
      default:     return BK_READ;
    endcase
  endfunction

endpackage

// File: rtl/cacheOpCtrl.sv
module cacheOpCtrl
  import cop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       reqDirect,
  input  logic       reqCoherent,
  input  logic       cfgNoTouch,
  input  logic       cacheLocked,
  input  logic       xlatDone,
  input  logic       xlatValid,
  input  logic       xlatLoadOk,
  input  logic       xlatInhibit,
  input  logic       l1Done,
  input  logic       l1Hit,
  input  logic       l2Done,
  input  logic       l2Hit,
  input  logic       busGrant,
  output logic       reqReady,
  output seqStrobeT  strobes
);

  seqStateT state, stateNext;
  logic     xlatFault;

  assign xlatFault = !xlatValid || !xlatLoadOk || xlatInhibit || cacheLocked;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext        = state;
    strobes          = '0;
    strobes.xlatOn   = (state == S_XLAT);
    strobes.l1On     = (state == S_L1);
    strobes.l2On     = (state == S_L2);
    strobes.busOn    = (state == S_BUS);
    strobes.doneOn   = (state == S_DONE);
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobes.capture = 1'b1;
          if (reqDirect) begin
            strobes.markNoop = 1'b1;
            stateNext        = S_DONE;
          end else if (isTouchOp(reqOp)) begin
            if (cfgNoTouch) begin
              strobes.markNoop = 1'b1;
              stateNext        = S_DONE;
            end else begin
              stateNext = S_XLAT;
            end
          end else if ((reqOp == OP_IINVAL) ||
                       (isCoherentBcast(reqOp) && reqCoherent)) begin
            stateNext = S_BUS;
          end else begin
            stateNext = S_DONE;
          end
        end
      end
      S_XLAT: begin
        if (xlatDone) begin
          if (xlatFault) begin
            strobes.markNoop = 1'b1;
            stateNext        = S_DONE;
          end else begin
            stateNext = S_L1;
          end
        end
      end
      S_L1: begin
        if (l1Done) stateNext = l1Hit ? S_DONE : S_L2;
      end
      S_L2: begin
        if (l2Done) stateNext = l2Hit ? S_DONE : S_BUS;
      end
      S_BUS: begin
        if (busGrant) stateNext = S_DONE;
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign reqReady = (state == S_IDLE);

endmodule

// File: rtl/cacheOpPath.sv
module cacheOpPath
  import cop_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LINE_BITS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  seqStrobeT     strobes,
  input  logic [2:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  output logic          xlatReq,
  output logic [AW-1:0] xlatAddr,
  output logic          l1Req,
  output logic [AW-1:0] l1Addr,
  output logic          l2Req,
  output logic [AW-1:0] l2Addr,
  output logic          busReq,
  output logic [2:0]    busKind,
  output logic [AW-1:0] busAddr,
  output logic          doneValid,
  output logic          doneNoop,
  input  logic          snoopValid,
  input  logic          snoopGlobal,
  input  logic [2:0]    snoopOp,
  input  logic [AW-1:0] snoopAddr,
  output logic          snoopAct,
  output logic [2:0]    snoopActOp,
  output logic [AW-1:0] snoopActAddr
);

  localparam logic [AW-1:0] LINE_MASK = {AW{1'b1}} << LINE_BITS;

  logic [2:0]    opReg;
  logic [AW-1:0] addrReg;
  logic          noopReg;
  logic [AW-1:0] lineAddr;

  always_ff @(posedge clk) begin
    if (rst) begin
      opReg   <= '0;
      addrReg <= '0;
      noopReg <= 1'b0;
    end else if (strobes.capture) begin
      opReg   <= reqOp;
      addrReg <= reqAddr;
      noopReg <= strobes.markNoop;
    end else if (strobes.markNoop) begin
      noopReg <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snoopAct     <= 1'b0;
      snoopActOp   <= '0;
      snoopActAddr <= '0;
    end else begin
      snoopAct <= snoopValid && snoopGlobal;
      if (snoopValid && snoopGlobal) begin
        snoopActOp   <= snoopOp;
        snoopActAddr <= snoopAddr;
      end
    end
  end

  assign lineAddr  = addrReg & LINE_MASK;
  assign xlatReq   = strobes.xlatOn;
  assign xlatAddr  = addrReg;
  assign l1Req     = strobes.l1On;
  assign l1Addr    = lineAddr;
  assign l2Req     = strobes.l2On;
  assign l2Addr    = lineAddr;
  assign busReq    = strobes.busOn;
  assign busKind   = kindOf(opReg);
  assign busAddr   = lineAddr;
  assign doneValid = strobes.doneOn;
  assign doneNoop  = strobes.doneOn && noopReg;

endmodule

// File: rtl/cacheOpSeq.sv
module cacheOpSeq
  import cop_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LINE_BITS = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [2:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic          reqDirect,
  input  logic          reqCoherent,
  input  logic          cfgNoTouch,
  input  logic          cacheLocked,
  output logic          xlatReq,
  output logic [AW-1:0] xlatAddr,
  input  logic          xlatDone,
  input  logic          xlatValid,
  input  logic          xlatLoadOk,
  input  logic          xlatInhibit,
  output logic          l1Req,
  output logic [AW-1:0] l1Addr,
  input  logic          l1Done,
  input  logic          l1Hit,
  output logic          l2Req,
  output logic [AW-1:0] l2Addr,
  input  logic          l2Done,
  input  logic          l2Hit,
  output logic          busReq,
  output logic [2:0]    busKind,
  output logic [AW-1:0] busAddr,
  input  logic          busGrant,
  output logic          doneValid,
  output logic          doneNoop,
  input  logic          snoopValid,
  input  logic          snoopGlobal,
  input  logic [2:0]    snoopOp,
  input  logic [AW-1:0] snoopAddr,
  output logic          snoopAct,
  output logic [2:0]    snoopActOp,
  output logic [AW-1:0] snoopActAddr
);

  seqStrobeT strobes;

  cacheOpCtrl u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqOp(reqOp),
    .reqDirect(reqDirect), .reqCoherent(reqCoherent),
    .cfgNoTouch(cfgNoTouch), .cacheLocked(cacheLocked),
    .xlatDone(xlatDone), .xlatValid(xlatValid), .xlatLoadOk(xlatLoadOk),
    .xlatInhibit(xlatInhibit), .l1Done(l1Done), .l1Hit(l1Hit),
    .l2Done(l2Done), .l2Hit(l2Hit), .busGrant(busGrant),
    .reqReady(reqReady), .strobes(strobes)
  );

  cacheOpPath #(.AW(AW), .LINE_BITS(LINE_BITS)) u_path (
    .clk(clk), .rst(rst), .strobes(strobes), .reqOp(reqOp), .reqAddr(reqAddr),
    .xlatReq(xlatReq), .xlatAddr(xlatAddr), .l1Req(l1Req), .l1Addr(l1Addr),
    .l2Req(l2Req), .l2Addr(l2Addr), .busReq(busReq), .busKind(busKind),
    .busAddr(busAddr), .doneValid(doneValid), .doneNoop(doneNoop),
    .snoopValid(snoopValid), .snoopGlobal(snoopGlobal), .snoopOp(snoopOp),
    .snoopAddr(snoopAddr), .snoopAct(snoopAct), .snoopActOp(snoopActOp),
    .snoopActAddr(snoopActAddr)
  );

endmodule

// File: rtl/cacheOpSeq_chk.sv
module cacheOpSeq_chk (
  input logic       clk,
  input logic       rst,
  input logic       reqValid,
  input logic       reqReady,
  input logic [2:0] reqOp,
  input logic       reqDirect,
  input logic       xlatReq,
  input logic       xlatDone,
  input logic       xlatValid,
  input logic       l1Req,
  input logic       l1Done,
  input logic       l1Hit,
  input logic       l2Req,
  input logic       busReq,
  input logic       busGrant,
  input logic       doneValid,
  input logic       doneNoop,
  input logic       snoopValid,
  input logic       snoopGlobal,
  input logic       snoopAct
);

  // R1
  one_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({xlatReq, l1Req, l2Req, busReq, doneValid}));

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (xlatReq || l1Req || l2Req || busReq || doneValid) |-> !reqReady);

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    doneValid |=> !doneValid);

  // R2
  direct_noop_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && reqDirect) |=> (doneValid && doneNoop));

  // R4
  xlat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (xlatReq && !xlatDone) |=> xlatReq);

  // R5
  xlat_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (xlatReq && xlatDone && !xlatValid) |=> (doneValid && doneNoop && !l1Req));

  // R6
  l1_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (l1Req && l1Done && l1Hit) |=> (doneValid && !doneNoop && !l2Req));

  // R9
  iinval_bcast_chk: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && !reqDirect && (reqOp == 3'd7)) |=> busReq);

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busGrant) |=> busReq);

  // R11
  bus_grant_done_chk: assert property (@(posedge clk) disable iff (rst)
    (busReq && busGrant) |=> (doneValid && !doneNoop && !busReq));

  // R12
  snoop_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (snoopValid && snoopGlobal) |=> snoopAct);

  // R12
  snoop_local_chk: assert property (@(posedge clk) disable iff (rst)
    !(snoopValid && snoopGlobal) |=> !snoopAct);

  // R13
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (reqReady && !xlatReq && !l1Req && !l2Req && !busReq && !doneValid && !snoopAct));

endmodule

bind cacheOpSeq cacheOpSeq_chk u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .reqOp(reqOp), .reqDirect(reqDirect), .xlatReq(xlatReq),
  .xlatDone(xlatDone), .xlatValid(xlatValid), .l1Req(l1Req),
  .l1Done(l1Done), .l1Hit(l1Hit), .l2Req(l2Req), .busReq(busReq),
  .busGrant(busGrant), .doneValid(doneValid), .doneNoop(doneNoop),
  .snoopValid(snoopValid), .snoopGlobal(snoopGlobal), .snoopAct(snoopAct)
);

// File: tb/cacheOpSeq_tb.sv
module cacheOpSeq_tb;

  localparam int AW = 32;
  localparam logic [AW-1:0] LMASK = 32'hFFFF_FFE0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 0, reqDirect = 0, reqCoherent = 0, cfgNoTouch = 0, cacheLocked = 0;
  logic [2:0] reqOp = 0;
  logic [AW-1:0] reqAddr = 0;
  logic xlatDone = 0, xlatValid = 0, xlatLoadOk = 0, xlatInhibit = 0;
  logic l1Done = 0, l1Hit = 0, l2Done = 0, l2Hit = 0, busGrant = 0;
  logic snoopValid = 0, snoopGlobal = 0;
  logic [2:0] snoopOp = 0;
  logic [AW-1:0] snoopAddr = 0;
  logic reqReady, xlatReq, l1Req, l2Req, busReq, doneValid, doneNoop, snoopAct;
  logic [AW-1:0] xlatAddr, l1Addr, l2Addr, busAddr, snoopActAddr;
  logic [2:0] busKind, snoopActOp;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cacheOpSeq u_dut (.*);

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic startOp(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic t, input logic m);
    reqOp = op; reqAddr = a; reqDirect = t; reqCoherent = m; reqValid = 1;
    tick;
    reqValid = 0;
  endtask

  task automatic expectDone(input string rq, input logic noop);
    chk(rq, "doneValid", doneValid, 1);
    chk(rq, "doneNoop", doneNoop, noop);
    chk(rq, "no request at done", {xlatReq, l1Req, l2Req, busReq}, 0);
    chk(rq, "ready at done", reqReady, 0);
    tick;
    chk(rq, "done pulse ends", doneValid, 0);
    chk(rq, "ready after done", reqReady, 1);
  endtask

  task automatic answerXlat(input logic v, input logic ok, input logic inh);
    xlatDone = 1; xlatValid = v; xlatLoadOk = ok; xlatInhibit = inh;
    tick;
    xlatDone = 0;
  endtask

  task automatic tReset;
    rst = 1; tick; tick; rst = 0;
    chk("R13", "ready after reset", reqReady, 1);
    chk("R13", "outputs idle", {xlatReq, l1Req, l2Req, busReq, doneValid, snoopAct}, 0);
  endtask

  task automatic tDirect;
    for (int op = 0; op < 8; op++) begin
      startOp(3'(op), 32'h1000 + op, 1, 1);
      expectDone("R2", 1);
    end
  endtask

  task automatic tNoTouch;
    cfgNoTouch = 1;
    startOp(0, 32'h2004, 0, 0);
    chk("R3", "xlatReq stays low", xlatReq, 0);
    expectDone("R3", 1);
    startOp(1, 32'h2008, 0, 0);
    expectDone("R3", 1);
    cfgNoTouch = 0;
  endtask

  task automatic tFault(input int kind);
    startOp(0, 32'h3456_789A, 0, 0);
    chk("R4", "xlatReq raised", xlatReq, 1);
    chk("R4", "xlatAddr byte", xlatAddr, 32'h3456_789A);
    tick;
    chk("R4", "xlatReq held", xlatReq, 1);
    cacheLocked = (kind == 3);
    answerXlat(kind != 0, kind != 1, kind == 2);
    cacheLocked = 0;
    chk("R5", "no L1 query", l1Req, 0);
    expectDone("R5", 1);
  endtask

  task automatic tTouchHit(input int level);
    startOp(0, 32'h0000_ABCD, 0, 0);
    answerXlat(1, 1, 0);
    chk("R6", "l1Req", l1Req, 1);
    chk("R6", "l1Addr line", l1Addr, 32'h0000_ABC0);
    l1Done = 1; l1Hit = (level == 1); tick; l1Done = 0; l1Hit = 0;
    if (level == 2) begin
      chk("R6", "l2Req after L1 miss", l2Req, 1);
      chk("R6", "l2Addr line", l2Addr, 32'h0000_ABC0);
      l2Done = 1; l2Hit = 1; tick; l2Done = 0; l2Hit = 0;
    end
    chk("R6", "no bus on hit", busReq, 0);
    expectDone("R6", 0);
  endtask

  task automatic tTouchBus(input logic [2:0] op, input logic [2:0] kind);
    logic [AW-1:0] a;
    a = 32'h7777_1235;
    startOp(op, a, 0, 0);
    answerXlat(1, 1, 0);
    l1Done = 1; tick; l1Done = 0;
    l2Done = 1; tick; l2Done = 0;
    chk("R7", "busReq after double miss", busReq, 1);
    chk("R7", "busKind", busKind, kind);
    chk("R7", "busAddr line", busAddr, a & LMASK);
    // concurrent snoop while the bus request waits
    snoopValid = 1; snoopGlobal = 1; snoopOp = 6; snoopAddr = 32'hCAFE_0040;
    tick;
    snoopValid = 0; snoopGlobal = 0;
    chk("R12", "snoopAct during bus wait", snoopAct, 1);
    chk("R12", "snoopActOp", snoopActOp, 6);
    chk("R12", "snoopActAddr", snoopActAddr, 32'hCAFE_0040);
    chk("R11", "busReq held", busReq, 1);
    busGrant = 1; snoopValid = 1; snoopGlobal = 1; snoopOp = 4; snoopAddr = 32'h10;
    tick;
    busGrant = 0; snoopValid = 0; snoopGlobal = 0;
    chk("R12", "snoop on grant cycle", snoopActOp, 4);
    chk("R11", "bus drops after grant", busReq, 0);
    expectDone("R11", 0);
  endtask

  task automatic tBcast(input logic [2:0] op, input logic m, input logic expBus,
                        input logic [2:0] kind, input string rq);
    startOp(op, 32'h0004_0044, 0, m);
    chk(rq, "busReq", busReq, expBus);
    if (expBus) begin
      chk(rq, "busKind", busKind, kind);
      chk(rq, "busAddr", busAddr, 32'h0004_0040);
      busGrant = 1; tick; busGrant = 0;
    end
    expectDone(rq, 0);
  endtask

  task automatic tSnoopLocal;
    snoopValid = 1; snoopGlobal = 0; snoopOp = 7; snoopAddr = 32'h55;
    tick;
    snoopValid = 0;
    chk("R12", "local snoop ignored", snoopAct, 0);
  endtask

  task automatic tBackToBack;
    startOp(2, 32'h100, 0, 0);
    reqOp = 5; reqAddr = 32'h200; reqValid = 1;
    chk("R1", "not ready during done", reqReady, 0);
    tick;
    chk("R1", "ready after done", reqReady, 1);
    tick;
    reqValid = 0;
    chk("R10", "second op done", doneValid, 1);
    chk("R10", "second op noop", doneNoop, 0);
    tick;
  endtask

  task automatic tResetMid;
    startOp(0, 32'h9000, 0, 0);
    chk("R13", "in translation", xlatReq, 1);
    rst = 1; tick; rst = 0;
    chk("R13", "requests cleared", {xlatReq, l1Req, l2Req, busReq, doneValid}, 0);
    chk("R13", "ready", reqReady, 1);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    tReset;
    tDirect;
    tNoTouch;
    for (int k = 0; k < 4; k++) tFault(k);
    tTouchHit(1);
    tTouchHit(2);
    tTouchBus(0, 0);
    tTouchBus(1, 1);
    tBcast(3, 1, 1, 2, "R8");
    tBcast(4, 1, 1, 3, "R8");
    tBcast(6, 1, 1, 4, "R8");
    tBcast(3, 0, 0, 0, "R8");
    tBcast(4, 0, 0, 0, "R8");
    tBcast(6, 0, 0, 0, "R8");
    tBcast(7, 0, 1, 5, "R9");
    tBcast(7, 1, 1, 5, "R9");
    tBcast(2, 1, 0, 0, "R10");
    tBcast(5, 1, 0, 0, "R10");
    tSnoopLocal;
    tBackToBack;
    tResetMid;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule